// File: doc/BRIEF.md
# Byte-Lane Static Memory Emulator

This block is a clock-sampled model of a 16-bit static memory with its control pins. It has two chip selects of opposite polarity, a write strobe, an output enable and one enable for each byte lane, all active low except the second chip select. On every rising clock edge it reads the control pins and picks one of four modes: standby, read, outputs disabled or write. It writes only the byte lanes that are enabled.

There are no real tri-state pins. The read bus comes with a per-lane drive vector, so a lane whose drive bit is low counts as high-impedance. A power flag tells the active modes apart from standby. The address port is the full 19 bits. The storage array is only `2**DEPTH_LOG2` words deep, and the address bits above that depth are ignored, so a bench or a system model can use the block without building the whole array.

Top module: `lane_sram`

## Requirements
- R1: While reset is high and on the first sample after it, `lane_drive` is 0, `power_active` is 0 and `rdata` is 0.
- R2: The device is selected only when `cs_n` is low and `cs` is high. When it is deselected, the next cycle shows `lane_drive` = 0 and `power_active` = 0, and no location is written.
- R3: When both bits of `byte_en_n` are high, the device is in standby with the same results as R2, whatever the other controls are, and nothing is written.
- R4: A selected cycle with `we_n` low is a write, whatever `oe_n` is. Bits 7:0 of `wdata` are stored when `byte_en_n[0]` is low, and bits 15:8 when `byte_en_n[1]` is low. In the next cycle `lane_drive` is 0 and `power_active` is 1.
- R5: A write with only one byte enable low leaves the stored byte of the other lane unchanged.
- R6: A selected cycle with `we_n` high and `oe_n` low is a read. One cycle later, `lane_drive[i]` is 1 exactly for the lanes whose `byte_en_n[i]` was low, and each such lane of `rdata` holds the byte last stored there. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R7: A selected cycle with `we_n` high, `oe_n` high and at least one lane enabled disables the outputs. In the next cycle `lane_drive` is 0 and `power_active` is 1.
- R8: `power_active` is 1 in the cycle after a read, write or outputs-disabled cycle, and 0 in the cycle after any standby cycle.
- R9: Address bits at and above `DEPTH_LOG2` are ignored. Two addresses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| cs | input | 1 | Chip select, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_en_n | input | 2 | Per-lane enables, active low; bit 0 is the low byte |
| addr | input | 19 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data; a lane is meaningful only while its drive bit is 1 |
| lane_drive | output | 2 | Per-lane drive flags; 0 stands for high-impedance |
| power_active | output | 1 | 1 in the active modes, 0 in standby |

## Verification
All three outputs are registered on the same edge that samples the controls. `lane_drive`, `power_active` and the read bytes for a cycle's controls are therefore due exactly one clock later, and a write first shows up on a read issued in a following cycle. The bench drives the controls on the falling edge and runs its behavioural model for that cycle. It then waits through one rising edge and compares all outputs on the next falling edge, so every result is sampled in the cycle it is due. Read data is compared only for lanes the model expects to be driven and whose bytes it has stored.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  typedef enum logic [1:0] {
    M_STANDBY = 2'd0,
    M_READ    = 2'd1,
    M_OUTOFF  = 2'd2,
    M_WRITE   = 2'd3
  } mode_t;
endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
  import lane_sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             cs,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  output mode_t            mode,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd
);
  logic selected;
  logic any_lane;

  always_comb begin
    selected = !cs_n && cs;
    any_lane = !(&lane_n);
    if (!selected || !any_lane) mode = M_STANDBY;
    else if (!we_n)             mode = M_WRITE;
    else if (!oe_n)             mode = M_READ;
    else                        mode = M_OUTOFF;
    lane_wr = (mode == M_WRITE) ? ~lane_n : '0;
    lane_rd = (mode == M_READ)  ? ~lane_n : '0;
  end
endmodule

// File: rtl/lane_sram_bank.sv
module lane_sram_bank #(
  parameter int W  = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] a,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (re) dout <= mem[a];
  end

  // R4 R6
  write_read_excl_chk: assert property (@(posedge clk) disable iff (rst) !(we && re));
endmodule

// File: rtl/lane_sram.sv
module lane_sram
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DEPTH_LOG2 = 10,
  parameter int LANE_W     = 8,
  parameter int LANES      = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    cs,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic [LANES-1:0]        byte_en_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_drive,
  output logic                    power_active
);
  mode_t                 mode;
  logic [LANES-1:0]      lane_wr;
  logic [LANES-1:0]      lane_rd;
  logic [DEPTH_LOG2-1:0] idx;

  assign idx = addr[DEPTH_LOG2-1:0];

  generate
    if (ADDR_W > DEPTH_LOG2) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:DEPTH_LOG2];
    end
  endgenerate

  lane_sram_decode #(.LANES(LANES)) u_dec (
    .cs_n   (cs_n),
    .cs     (cs),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .lane_n (byte_en_n),
    .mode   (mode),
    .lane_wr(lane_wr),
    .lane_rd(lane_rd)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      lane_sram_bank #(.W(LANE_W), .AW(DEPTH_LOG2)) u_bank (
        .clk (clk),
        .rst (rst),
        .we  (lane_wr[i]),
        .re  (lane_rd[i]),
        .a   (idx),
        .din (wdata[i*LANE_W +: LANE_W]),
        .dout(rdata[i*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_drive   <= '0;
      power_active <= 1'b0;
    end else begin
      lane_drive   <= lane_rd;
      power_active <= (mode != M_STANDBY);
    end
  end

  // R2
  deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !cs) |=> (lane_drive == '0 && !power_active));

  // R3
  no_lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (&byte_en_n) |=> (lane_drive == '0 && !power_active));

  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cs && !we_n && !(&byte_en_n)) |=> (lane_drive == '0 && power_active));

  // R6
  read_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cs && we_n && !oe_n && !(&byte_en_n)) |=> (lane_drive == ~$past(byte_en_n)));

  // R7
  out_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cs && we_n && oe_n && !(&byte_en_n)) |=> (lane_drive == '0 && power_active));

  // R8
  drive_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_drive != '0) |-> power_active);
endmodule

// File: tb/sim_lane_sram.sv
`timescale 1ns/1ps
module sim_lane_sram;
  localparam int AW = 19;
  localparam int DL = 10;
  localparam int DEPTH = 1 << DL;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, cs, we_n, oe_n;
  logic [1:0]  byte_en_n;
  logic [18:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  lane_drive;
  logic        power_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] ref_lo [int];
  logic [7:0] ref_hi [int];

  always #4 clk = ~clk;

  lane_sram #(.ADDR_W(AW), .DEPTH_LOG2(DL)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cs(cs), .we_n(we_n), .oe_n(oe_n),
    .byte_en_n(byte_en_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .lane_drive(lane_drive), .power_active(power_active)
  );

  task automatic report_summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
        report_summary();
        $finish;
      end
    end
  end

  task automatic step(input logic sn, input logic sh, input logic w, input logic o,
                      input logic [1:0] be, input logic [18:0] a, input logic [15:0] d,
                      input string tag);
    logic       sel, act;
    logic [1:0] e_drv;
    int         idx;
    cs_n = sn; cs = sh; we_n = w; oe_n = o; byte_en_n = be; addr = a; wdata = d;
    idx   = int'(a) % DEPTH;
    sel   = !sn && sh;
    act   = sel && !(be[0] && be[1]);
    e_drv = 2'b00;
    if (act && !w) begin
      if (!be[0]) ref_lo[idx] = d[7:0];
      if (!be[1]) ref_hi[idx] = d[15:8];
    end else if (act && !o) begin
      e_drv = ~be;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (lane_drive !== e_drv) begin
      errors++;
      $display("FAIL %s lane_drive: actual %b expected %b", tag, lane_drive, e_drv);
    end
    checks++;
    if (power_active !== act) begin
      errors++;
      $display("FAIL %s power_active: actual %b expected %b", tag, power_active, act);
    end
    if (e_drv[0] && ref_lo.exists(idx)) begin
      checks++;
      if (rdata[7:0] !== ref_lo[idx]) begin
        errors++;
        $display("FAIL %s low byte @%0d: actual %h expected %h", tag, idx, rdata[7:0], ref_lo[idx]);
      end
    end
    if (e_drv[1] && ref_hi.exists(idx)) begin
      checks++;
      if (rdata[15:8] !== ref_hi[idx]) begin
        errors++;
        $display("FAIL %s high byte @%0d: actual %h expected %h", tag, idx, rdata[15:8], ref_hi[idx]);
      end
    end
  endtask

  initial begin
    rst = 1'b1; cs_n = 1'b1; cs = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    byte_en_n = 2'b11; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checks++;
    if (lane_drive !== 2'b00 || power_active !== 1'b0 || rdata !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset: actual %b %b %h expected 00 0 0000", lane_drive, power_active, rdata);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (lane_drive !== 2'b00 || power_active !== 1'b0 || rdata !== 16'h0) begin
      errors++;
      $display("FAIL R1 after reset: actual %b %b %h expected 00 0 0000", lane_drive, power_active, rdata);
    end

    // R4 full-word writes, with oe_n low and high
    step(0, 1, 0, 1, 2'b00, 19'd5,  16'hA55A, "R4");
    step(0, 1, 0, 0, 2'b00, 19'd6,  16'h1234, "R4");
    step(0, 1, 0, 1, 2'b00, 19'd7,  16'hBEEF, "R4");
    // R6 full-word reads
    step(0, 1, 1, 0, 2'b00, 19'd5,  16'h0, "R6");
    step(0, 1, 1, 0, 2'b00, 19'd6,  16'h0, "R6");
    step(0, 1, 1, 0, 2'b00, 19'd7,  16'h0, "R6");
    // R6 single-lane reads
    step(0, 1, 1, 0, 2'b10, 19'd7,  16'h0, "R6");
    step(0, 1, 1, 0, 2'b01, 19'd7,  16'h0, "R6");
    // R5 partial writes keep the other lane
    step(0, 1, 0, 1, 2'b10, 19'd5,  16'hFF11, "R5");
    step(0, 1, 1, 0, 2'b00, 19'd5,  16'h0, "R5");
    step(0, 1, 0, 0, 2'b01, 19'd6,  16'h77EE, "R5");
    step(0, 1, 1, 0, 2'b00, 19'd6,  16'h0, "R5");
    // R7 outputs disabled
    step(0, 1, 1, 1, 2'b00, 19'd5,  16'h0, "R7");
    step(0, 1, 1, 1, 2'b01, 19'd5,  16'h0, "R7");
    // R2 deselected write attempts do nothing
    step(1, 1, 0, 0, 2'b00, 19'd7,  16'h0000, "R2");
    step(0, 0, 0, 0, 2'b00, 19'd7,  16'h1111, "R2");
    step(1, 0, 1, 0, 2'b00, 19'd7,  16'h0, "R2");
    step(0, 1, 1, 0, 2'b00, 19'd7,  16'h0, "R2");
    // R3 both byte enables high
    step(0, 1, 0, 0, 2'b11, 19'd7,  16'h2222, "R3");
    step(0, 1, 1, 0, 2'b11, 19'd7,  16'h0, "R3");
    step(0, 1, 1, 0, 2'b00, 19'd7,  16'h0, "R3");
    // R9 aliasing through the ignored upper address bits
    step(0, 1, 1, 0, 2'b00, 19'd5 + 19'(DEPTH),     16'h0, "R9");
    step(0, 1, 0, 1, 2'b00, 19'd9 + 19'(DEPTH * 37), 16'hC0DE, "R9");
    step(0, 1, 1, 0, 2'b00, 19'd9,  16'h0, "R9");
    // R8 power transitions
    step(1, 0, 1, 1, 2'b11, 19'd0,  16'h0, "R8");
    step(0, 1, 1, 1, 2'b10, 19'd0,  16'h0, "R8");
    step(0, 1, 1, 1, 2'b11, 19'd0,  16'h0, "R8");
    // mixed pattern sweep
    for (int k = 0; k < 40; k++) begin
      step(0, 1, 0, k[0], 2'(k % 3), 19'(k * 13 + 100), 16'(k * 16'h0507 + 16'h3C1), "R4");
    end
    for (int k = 0; k < 40; k++) begin
      step(0, 1, 1, 0, 2'(k % 3), 19'(k * 13 + 100), 16'h0, "R6");
    end
    report_summary();
    $finish;
  end
endmodule